// File: doc/BRIEF.md
# Auxiliary XRAM Access Router

This block sits between a simple core bus model and two data stores: a 1 KB on-chip auxiliary data RAM and an external multiplexed data memory bus. For each external-data read or write the core presents, the block forms a 16-bit address and decides where the access goes. The address comes either from the 16-bit data pointer, or from an 8-bit pointer register combined with a high-address register. The access is served by the on-chip RAM when routing is enabled and the address lies in the low 1 KB window. Otherwise it runs as an external bus cycle with an address phase and a strobe phase.

Three special-function registers control the routing. A key register takes a two-byte unlock sequence. A control register holds the routing enable bit and can be written only while the key register is unlocked. A high-address register supplies the upper byte for accesses made through a pointer register.

Requests use a valid/ready handshake. An access is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls while an external bus cycle is in progress, and the request fields must then be held until acceptance. Read responses have no back-pressure: `rsp_valid` is high for exactly one cycle and the core must take the data in that cycle. The SFR port is plain. Writes take effect at the clock edge, and `sfr_rdata` follows `sfr_addr` combinationally.

Top module: `xram_router`

## Requirements
- R1: After reset the control register and the high-address register read 0x00, the key register reads 0x00 (locked), and the external bus is idle: `ext_ale`=0, `ext_rd_n`=1, `ext_wr_n`=1, `ext_p0_oe`=0, `ext_p2_o`=0xFF.
- R2: The key register sits at SFR address 0xF6. A write of 0x87 arms the lock. A write of 0x59 made directly after that arming write unlocks it. Any other written byte, 0x00 included, locks it. The key register reads 0x01 while unlocked and 0x00 otherwise.
- R3: The control register sits at SFR address 0xBF. A write to it while locked leaves its value unchanged. A write while unlocked stores the full byte. A read returns the stored value.
- R4: The high-address register sits at SFR address 0xA1. It is writable at any time and reads back the byte last written.
- R5: With `req_use_dptr`=0 the access address is {high-address register, `req_ptr`}. With `req_use_dptr`=1 it is `req_dptr`.
- R6: An access is served on-chip exactly when bit 4 of the control register is 1 and the access address is below 0x400. Every other access runs on the external bus. The on-chip location used is the low 10 address bits.
- R7: While an on-chip access is accepted, and in the cycle after it, the external bus stays at its idle values.
- R8: For an on-chip read, `rsp_valid`=1 and `rsp_onchip`=1 in the cycle after acceptance, and `rsp_data` is the byte last written to that location. `req_ready` stays 1, so on-chip accesses can follow back to back.
- R9: An external access takes two phases. In the cycle after acceptance, `ext_ale`=1, `ext_p0_oe`=1, `ext_p0_o` carries the low address byte and `ext_p2_o` the high address byte. In the next cycle `ext_rd_n` or `ext_wr_n` is 0 for exactly one cycle with `ext_p2_o` held; a write drives its data on `ext_p0_o` with `ext_p0_oe`=1. A read samples `ext_p0_i` at the end of the strobe and presents it with `rsp_valid`=1 and `rsp_onchip`=0 in the following cycle.
- R10: `req_ready` is 0 in both phases of an external access and returns to 1 in the cycle after the strobe. `ext_rd_n` and `ext_wr_n` are never both 0.
- R11: When an SFR write and an accepted request fall in the same cycle, the request is routed and addressed with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_use_dptr | input | 1 | 1 = 16-bit data pointer, 0 = 8-bit pointer register |
| req_ptr | input | 8 | 8-bit pointer register value |
| req_dptr | input | 16 | 16-bit data pointer value |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read data |
| rsp_onchip | output | 1 | Response came from the on-chip RAM |
| ext_p0_o | output | 8 | External low address / data out |
| ext_p0_oe | output | 1 | Drive enable for ext_p0_o |
| ext_p0_i | input | 8 | External read data in |
| ext_p2_o | output | 8 | External high address |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |

## Verification
An SFR write and the acceptance of an access request can fall in the same clock cycle. The conflict matters when the write targets the high-address register or the control register, because either one changes the address or the routing of that very request. The bench provokes this by raising `sfr_wr` and `req_valid` on the same edge, once changing the high byte and once clearing the enable bit. It judges the outcome from the ports: the request must land where the old register values send it, either on-chip with the old data or on the bus with the old address bytes on P2. The request that follows must then use the new values.

// File: rtl/xram_pkg.sv
package xram_pkg;
  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_ARMED  = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  typedef enum logic [1:0] {
    XB_IDLE   = 2'd0,
    XB_ADDR   = 2'd1,
    XB_STROBE = 2'd2
  } xbus_state_e;

  typedef struct packed {
    logic        write;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } xacc_t;

  localparam logic [7:0] BUS_IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/xram_sfr.sv
module xram_sfr
  import xram_pkg::*;
#(
  parameter logic [7:0] KEY_ADDR  = 8'hF6,
  parameter logic [7:0] CTRL_ADDR = 8'hBF,
  parameter logic [7:0] HI_ADDR   = 8'hA1,
  parameter logic [7:0] KEY_FIRST = 8'h87,
  parameter logic [7:0] KEY_SECOND = 8'h59,
  parameter int         EN_BIT    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] ctrl_q,
  output logic [7:0] hi_q,
  output logic       key_open,
  output logic       route_en
);
  key_state_e key_q, key_d;
  logic key_wr, ctrl_wr, hi_wr;

  assign key_wr  = wr && (addr == KEY_ADDR);
  assign ctrl_wr = wr && (addr == CTRL_ADDR);
  assign hi_wr   = wr && (addr == HI_ADDR);

  always_comb begin
    key_d = key_q;
    if (key_wr) begin
      if (wdata == KEY_FIRST)
        key_d = KEY_ARMED;
      else if (key_q == KEY_ARMED && wdata == KEY_SECOND)
        key_d = KEY_OPEN;
      else
        key_d = KEY_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= KEY_LOCKED;
      ctrl_q <= 8'h00;
      hi_q   <= 8'h00;
    end else begin
      key_q <= key_d;
      if (ctrl_wr && key_q == KEY_OPEN)
        ctrl_q <= wdata;
      if (hi_wr)
        hi_q <= wdata;
    end
  end

  assign key_open = (key_q == KEY_OPEN);
  assign route_en = ctrl_q[EN_BIT];

  always_comb begin
    unique case (addr)
      KEY_ADDR:  rdata = {7'd0, key_open};
      CTRL_ADDR: rdata = ctrl_q;
      HI_ADDR:   rdata = hi_q;
      default:   rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/xram_addr.sv
module xram_addr #(
  parameter int AW     = 16,
  parameter int PW     = 8,
  parameter int RAM_AW = 10
) (
  input  logic          use_dptr,
  input  logic [PW-1:0] ptr,
  input  logic [AW-1:0] dptr,
  input  logic [AW-PW-1:0] hi,
  input  logic          route_en,
  output logic [AW-1:0] addr,
  output logic          onchip
);
  localparam int TOP_W = AW - RAM_AW;

  logic in_window;

  assign addr      = use_dptr ? dptr : {hi, ptr};
  assign in_window = (addr[AW-1:RAM_AW] == {TOP_W{1'b0}});
  assign onchip    = route_en && in_window;
endmodule

// File: rtl/xram_store.sv
module xram_store #(
  parameter int RAM_AW = 10,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [RAM_AW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[idx] <= wdata;
    if (re)
      rdata <= mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rvalid <= 1'b0;
    else
      rvalid <= re;
  end
endmodule

// File: rtl/xram_xbus.sv
module xram_xbus
  import xram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  xacc_t      acc,
  output logic       busy,
  output logic [7:0] p0_o,
  output logic       p0_oe,
  input  logic [7:0] p0_i,
  output logic [7:0] p2_o,
  output logic       ale,
  output logic       rd_n,
  output logic       wr_n,
  output logic       rvalid,
  output logic [7:0] rdata
);
  xbus_state_e st_q;
  xacc_t       acc_q;
  logic        in_addr, in_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XB_IDLE;
      acc_q  <= '0;
      rvalid <= 1'b0;
      rdata  <= 8'h00;
    end else begin
      rvalid <= 1'b0;
      unique case (st_q)
        XB_IDLE: if (start) begin
          st_q  <= XB_ADDR;
          acc_q <= acc;
        end
        XB_ADDR: st_q <= XB_STROBE;
        XB_STROBE: begin
          st_q <= XB_IDLE;
          if (!acc_q.write) begin
            rvalid <= 1'b1;
            rdata  <= p0_i;
          end
        end
        default: st_q <= XB_IDLE;
      endcase
    end
  end

  assign in_addr   = (st_q == XB_ADDR);
  assign in_strobe = (st_q == XB_STROBE);
  assign busy      = (st_q != XB_IDLE);

  assign ale   = in_addr;
  assign p0_oe = in_addr || (in_strobe && acc_q.write);
  assign p0_o  = in_addr ? acc_q.addr[7:0]
               : (in_strobe && acc_q.write) ? acc_q.wdata : BUS_IDLE_BYTE;
  assign p2_o  = busy ? acc_q.addr[15:8] : BUS_IDLE_BYTE;
  assign rd_n  = !(in_strobe && !acc_q.write);
  assign wr_n  = !(in_strobe && acc_q.write);
endmodule

// File: rtl/xram_router.sv
module xram_router
  import xram_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int EN_BIT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sfr_wr,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_use_dptr,
  input  logic [7:0]  req_ptr,
  input  logic [15:0] req_dptr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        rsp_onchip,
  output logic [7:0]  ext_p0_o,
  output logic        ext_p0_oe,
  input  logic [7:0]  ext_p0_i,
  output logic [7:0]  ext_p2_o,
  output logic        ext_ale,
  output logic        ext_rd_n,
  output logic        ext_wr_n
);
  logic [7:0]  ctrl_q, hi_q;
  logic        key_open, route_en;
  logic [15:0] acc_addr;
  logic        acc_onchip;
  logic        fire, fire_onchip, fire_ext;
  logic        xbus_busy, xbus_rvalid, store_rvalid;
  logic [7:0]  xbus_rdata, store_rdata;
  xacc_t       acc;

  xram_sfr #(.EN_BIT(EN_BIT)) sfr_i (
    .clk(clk), .rst_n(rst_n), .wr(sfr_wr), .addr(sfr_addr),
    .wdata(sfr_wdata), .rdata(sfr_rdata), .ctrl_q(ctrl_q), .hi_q(hi_q),
    .key_open(key_open), .route_en(route_en)
  );

  xram_addr #(.AW(16), .PW(8), .RAM_AW(RAM_AW)) addr_i (
    .use_dptr(req_use_dptr), .ptr(req_ptr), .dptr(req_dptr), .hi(hi_q),
    .route_en(route_en), .addr(acc_addr), .onchip(acc_onchip)
  );

  assign req_ready   = !xbus_busy;
  assign fire        = req_valid && req_ready;
  assign fire_onchip = fire && acc_onchip;
  assign fire_ext    = fire && !acc_onchip;

  assign acc.write = req_write;
  assign acc.addr  = acc_addr;
  assign acc.wdata = req_wdata;

  xram_store #(.RAM_AW(RAM_AW), .DW(8)) store_i (
    .clk(clk), .rst_n(rst_n),
    .we(fire_onchip && req_write), .re(fire_onchip && !req_write),
    .idx(acc_addr[RAM_AW-1:0]), .wdata(req_wdata),
    .rdata(store_rdata), .rvalid(store_rvalid)
  );

  xram_xbus xbus_i (
    .clk(clk), .rst_n(rst_n), .start(fire_ext), .acc(acc), .busy(xbus_busy),
    .p0_o(ext_p0_o), .p0_oe(ext_p0_oe), .p0_i(ext_p0_i), .p2_o(ext_p2_o),
    .ale(ext_ale), .rd_n(ext_rd_n), .wr_n(ext_wr_n),
    .rvalid(xbus_rvalid), .rdata(xbus_rdata)
  );

  assign rsp_valid  = store_rvalid || xbus_rvalid;
  assign rsp_onchip = store_rvalid;
  assign rsp_data   = store_rvalid ? store_rdata : xbus_rdata;
endmodule

// File: rtl/xram_router_chk.sv
module xram_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sfr_wr,
  input logic [7:0] sfr_addr,
  input logic [7:0] ctrl_q,
  input logic       key_open,
  input logic       fire_onchip,
  input logic       req_ready,
  input logic       store_rvalid,
  input logic       xbus_rvalid,
  input logic [7:0] ext_p2_o,
  input logic       ext_p0_oe,
  input logic       ext_ale,
  input logic       ext_rd_n,
  input logic       ext_wr_n
);
  // R3
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == 8'hBF && !key_open) |=> $stable(ctrl_q));

  // R7
  onchip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_onchip |=> (!ext_ale && ext_rd_n && ext_wr_n && !ext_p0_oe && ext_p2_o == 8'hFF));

  // R9
  strobe_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ext_rd_n) || $fell(ext_wr_n)) |-> $past(ext_ale));

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |=> (ext_rd_n && ext_wr_n));

  // R9
  p2_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> $stable(ext_p2_o));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ale || !ext_rd_n || !ext_wr_n) |-> !req_ready);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  // R8
  rsp_source_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_rvalid && xbus_rvalid));
endmodule

bind xram_router xram_router_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
  .ctrl_q(ctrl_q), .key_open(key_open), .fire_onchip(fire_onchip),
  .req_ready(req_ready), .store_rvalid(store_rvalid), .xbus_rvalid(xbus_rvalid),
  .ext_p2_o(ext_p2_o), .ext_p0_oe(ext_p0_oe), .ext_ale(ext_ale),
  .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
);

// File: tb/xram_router_tb.sv
module xram_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00, sfr_rdata;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_use_dptr = 1'b0;
  logic [7:0] req_ptr = 8'h00, req_wdata = 8'h00;
  logic [15:0] req_dptr = 16'h0000;
  logic rsp_valid, rsp_onchip;
  logic [7:0] rsp_data;
  logic [7:0] ext_p0_o, ext_p2_o, ext_p0_i = 8'h00;
  logic ext_p0_oe, ext_ale, ext_rd_n, ext_wr_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xram_router dut_i (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_use_dptr(req_use_dptr),
    .req_ptr(req_ptr), .req_dptr(req_dptr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_onchip(rsp_onchip),
    .ext_p0_o(ext_p0_o), .ext_p0_oe(ext_p0_oe), .ext_p0_i(ext_p0_i),
    .ext_p2_o(ext_p2_o), .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) ^ (a >> 8));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic bus_idle(input string req);
    chk(!ext_ale && ext_rd_n && ext_wr_n && !ext_p0_oe && ext_p2_o == 8'hFF, req,
        {ext_ale, ext_rd_n, ext_wr_n, ext_p0_oe, ext_p2_o}, 12'h6FF);
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_expect(input logic [7:0] a, input logic [7:0] e, input string req);
    sfr_addr = a;
    #1;
    chk(sfr_rdata == e, req, sfr_rdata, e);
  endtask

  task automatic set_req(input bit wr, input bit dp, input logic [15:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_use_dptr = dp;
    req_ptr = a[7:0]; req_dptr = a; req_wdata = d;
  endtask

  // On-chip access: R7, R8
  task automatic onchip_acc(input bit wr, input bit dp, input logic [15:0] a,
                            input logic [7:0] d, input logic [7:0] exp_rd);
    @(negedge clk);
    set_req(wr, dp, a, d);
    #1;
    chk(req_ready, "R8", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    bus_idle("R7");
    chk(req_ready, "R8", req_ready, 1);
    if (!wr) begin
      chk(rsp_valid && rsp_onchip && rsp_data == exp_rd, "R8",
          {rsp_valid, rsp_onchip, rsp_data}, {2'b11, exp_rd});
    end else begin
      chk(!rsp_valid, "R8", rsp_valid, 0);
    end
  endtask

  // External access: R9, R10; exp_addr is the address that must appear
  task automatic ext_acc(input bit wr, input bit dp, input logic [15:0] a,
                         input logic [7:0] d, input logic [15:0] exp_addr, input string req);
    logic [7:0] rd_byte;
    rd_byte = exp_addr[7:0] ^ 8'hA5;
    @(negedge clk);
    set_req(wr, dp, a, d);
    #1;
    chk(req_ready, "R10", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(ext_ale && ext_p0_oe && ext_p0_o == exp_addr[7:0] && ext_p2_o == exp_addr[15:8]
        && ext_rd_n && ext_wr_n, req, {ext_p2_o, ext_p0_o}, exp_addr);
    chk(!req_ready, "R10", req_ready, 0);
    ext_p0_i = rd_byte;
    @(negedge clk);
    chk(!ext_ale && ext_p2_o == exp_addr[15:8] && ext_rd_n == wr && ext_wr_n == !wr,
        "R9", {ext_ale, ext_rd_n, ext_wr_n, ext_p2_o}, {1'b0, wr, !wr, exp_addr[15:8]});
    if (wr) chk(ext_p0_oe && ext_p0_o == d, "R9", ext_p0_o, d);
    else    chk(!ext_p0_oe, "R9", ext_p0_oe, 0);
    chk(!req_ready, "R10", req_ready, 0);
    @(negedge clk);
    ext_p0_i = 8'h00;
    chk(ext_rd_n && ext_wr_n && req_ready, "R10", {ext_rd_n, ext_wr_n, req_ready}, 3'b111);
    if (!wr) chk(rsp_valid && !rsp_onchip && rsp_data == rd_byte, "R9",
                 {rsp_valid, rsp_onchip, rsp_data}, {2'b10, rd_byte});
    else     chk(!rsp_valid, "R9", rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_idle("R1");
    chk(!rsp_valid && req_ready, "R1", {rsp_valid, req_ready}, 2'b01);
    sfr_expect(8'hBF, 8'h00, "R1");
    sfr_expect(8'hA1, 8'h00, "R1");
    sfr_expect(8'hF6, 8'h00, "R1");
    rst_n = 1'b1;

    // R2 sweep of first and second key bytes
    for (int b = 0; b < 256; b++) begin
      sfr_write(8'hF6, 8'(b));
      sfr_write(8'hF6, 8'h59);
      sfr_expect(8'hF6, (b == 8'h87) ? 8'h01 : 8'h00, "R2");
      sfr_write(8'hF6, 8'h00);
      sfr_expect(8'hF6, 8'h00, "R2");
    end
    for (int b = 0; b < 256; b++) begin
      sfr_write(8'hF6, 8'h87);
      sfr_write(8'hF6, 8'(b));
      sfr_expect(8'hF6, (b == 8'h59) ? 8'h01 : 8'h00, "R2");
      sfr_write(8'hF6, 8'h00);
    end

    // R3 control register gating
    sfr_write(8'hBF, 8'h10);
    sfr_expect(8'hBF, 8'h00, "R3");
    ext_acc(1'b1, 1'b0, 16'h0023, 8'h11, 16'h0023, "R6");
    sfr_write(8'hF6, 8'h87); sfr_write(8'hF6, 8'h59);
    sfr_write(8'hBF, 8'h5A);
    sfr_expect(8'hBF, 8'h5A, "R3");
    sfr_write(8'hF6, 8'h00);
    sfr_write(8'hBF, 8'hFF);
    sfr_expect(8'hBF, 8'h5A, "R3");
    sfr_write(8'hF6, 8'h87); sfr_write(8'hF6, 8'h59);
    sfr_write(8'hBF, 8'h10);
    sfr_write(8'hF6, 8'h00);
    sfr_expect(8'hBF, 8'h10, "R3");

    // R4 high-address sweep
    for (int v = 0; v < 256; v++) begin
      sfr_write(8'hA1, 8'(v));
      sfr_expect(8'hA1, 8'(v), "R4");
    end

    // R5 R6 R8: fill on-chip RAM via pointer mode, read back via data pointer
    for (int a = 0; a < 1024; a++) begin
      if ((a & 255) == 0) sfr_write(8'hA1, 8'(a >> 8));
      onchip_acc(1'b1, 1'b0, 16'(a), pat(a), 8'h00);
    end
    for (int a = 0; a < 1024; a++)
      onchip_acc(1'b0, 1'b1, 16'(a), 8'h00, pat(a));
    for (int a = 0; a < 1024; a += 61) begin
      sfr_write(8'hA1, 8'(a >> 8));
      onchip_acc(1'b0, 1'b0, 16'(a), 8'h00, pat(a));
    end

    // R6 window boundary and R9 external writes/reads
    onchip_acc(1'b0, 1'b1, 16'h03FF, 8'h00, pat(16'h03FF));
    ext_acc(1'b0, 1'b1, 16'h0400, 8'h00, 16'h0400, "R6");
    ext_acc(1'b0, 1'b1, 16'h7FFF, 8'h00, 16'h7FFF, "R6");
    ext_acc(1'b1, 1'b1, 16'hC3A9, 8'h3C, 16'hC3A9, "R9");
    sfr_write(8'hA1, 8'h04);
    ext_acc(1'b1, 1'b0, 16'h0000, 8'hE7, 16'h0400, "R5");
    sfr_write(8'hA1, 8'hFF);
    ext_acc(1'b0, 1'b0, 16'h0012, 8'h00, 16'hFF12, "R5");
    onchip_acc(1'b0, 1'b1, 16'h0000, 8'h00, pat(0));

    // R11: high-address write in the same cycle as a request
    sfr_write(8'hA1, 8'h01);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = 8'hA1; sfr_wdata = 8'h05;
    set_req(1'b0, 1'b0, 16'h0033, 8'h00);
    @(negedge clk);
    sfr_wr = 1'b0; req_valid = 1'b0;
    chk(rsp_valid && rsp_onchip && rsp_data == pat(16'h0133), "R11",
        {rsp_valid, rsp_onchip, rsp_data}, {2'b11, pat(16'h0133)});
    bus_idle("R11");
    ext_acc(1'b0, 1'b0, 16'h0033, 8'h00, 16'h0533, "R11");

    // R11: control disable in the same cycle as a request
    sfr_write(8'hF6, 8'h87); sfr_write(8'hF6, 8'h59);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = 8'hBF; sfr_wdata = 8'h00;
    set_req(1'b0, 1'b1, 16'h0200, 8'h00);
    @(negedge clk);
    sfr_wr = 1'b0; req_valid = 1'b0;
    chk(rsp_valid && rsp_onchip && rsp_data == pat(16'h0200), "R11",
        {rsp_valid, rsp_onchip, rsp_data}, {2'b11, pat(16'h0200)});
    ext_acc(1'b0, 1'b1, 16'h0200, 8'h00, 16'h0200, "R11");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule